// File: doc/BRIEF.md
# Byte-Wide SPI Master with Strobe Handshake

This block is a register-mapped SPI master that moves exactly one byte per transfer to one of two attached peripherals. A host sees two 16-bit registers: a data register holding the outgoing byte (and, after a read, the incoming byte) and a control register that holds two select bits, a direction bit, a load strobe and two read-only flags. Words longer than one byte are sent by the host as a run of byte transfers, most significant byte first, while the select bit stays set.

A transfer uses a two-phase handshake instead of a go bit. The host sets the strobe and waits for the `loaded` flag. It then clears the strobe, and only then does shifting begin. When the eighth bit has gone out, `done` is set. The controller is a three-state machine. `ST_IDLE` moves to `ST_ARMED` when the strobe is seen (accept: the shift register is loaded and `done` is cleared). `ST_ARMED` moves to `ST_SHIFT` once the strobe is low (release). `ST_SHIFT` returns to `ST_IDLE` on the eighth falling SCLK edge (finish: `done` is set). The SPI timing is mode 0, and SCLK is derived from the system clock by a parameterised divider.

Top module: `spi_byte_shifter`

## Requirements
- R1: The control register reads back select 0 in bit 0, select 1 in bit 1, direction in bit 2 (1 = read), the done flag in bit 3, the strobe in bit 4 and the loaded flag in bit 5; bits 15:6 read 0. Register address 0 is data and address 1 is control.
- R2: The loaded flag reads 1 exactly one clock after the strobe bit has been registered while the controller is idle. The done flag is cleared in that same cycle.
- R3: While the strobe stays high after loaded is set, SCLK stays low and loaded stays 1. Shifting begins only after the strobe is written back to 0, and loaded then returns to 0.
- R4: Each transfer puts 8 bits on MOSI, most significant bit first, in SPI mode 0. SCLK idles low, MOSI changes only after falling edges, and MOSI is stable while SCLK is high.
- R5: MISO is sampled on rising SCLK edges, most significant bit first. At the end of a read transfer (direction = 1), the data register holds the received byte in bits 7:0 with bits 15:8 zero. A write transfer leaves the data register unchanged.
- R6: The done flag sets when the eighth falling SCLK edge completes the byte. It stays set until the next strobe is accepted.
- R7: Every SCLK high phase lasts DIV_HALF system clocks.
- R8: `cs_n[i]` is the inverse of control bit i with no clock delay. Writing 0 to the control register deasserts both selects.
- R9: A select bit left set across consecutive byte transfers keeps its chip select asserted between bytes. A 16-bit word built from two bytes comes back as (first << 8) | second.
- R10: Host writes to control bits 3 and 5 have no effect on the done and loaded flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |
| cs_n | output | 2 | Active-low chip selects for peripheral 0 and 1 |

## Verification
The bench builds the block with DIV_HALF = 3, an odd half period. With this value the divider counter must wrap at a value that is not a power of two, and each byte still finishes in about fifty clocks. This keeps the handshake polling, the high-phase timing check and several multi-byte words well inside the run. BYTE_W stays at 8, so the scoreboard works on whole bytes, exactly as a host would build 8-bit and 16-bit words.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
    // Control register bit positions (the host software decodes these)
    localparam int CB_SEL0   = 0;
    localparam int CB_SEL1   = 1;
    localparam int CB_DIR    = 2;
    localparam int CB_DONE   = 3;
    localparam int CB_STROBE = 4;
    localparam int CB_LOADED = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHIFT
    } xfer_state_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_byte_fsm.sv
module spi_byte_fsm
    import spi_shift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic last_fall,
    output logic load,
    output logic run,
    output logic loaded,
    output logic done
);
    xfer_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (strobe)    state_d = ST_ARMED;
            ST_ARMED: if (!strobe)   state_d = ST_SHIFT;
            ST_SHIFT: if (last_fall) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        run    = 1'b0;
        loaded = 1'b0;
        unique case (state_q)
            ST_IDLE:  load   = strobe;
            ST_ARMED: loaded = 1'b1;
            ST_SHIFT: run    = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         done <= 1'b0;
        else if (load)      done <= 1'b0;
        else if (last_fall) done <= 1'b1;
    end

    // R2
    loaded_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && strobe) |=> (loaded && !done));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(state_q == ST_IDLE && strobe)) |=> done);

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !loaded);
endmodule

// File: rtl/spi_byte_shreg.sv
module spi_byte_shreg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              run,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              last_fall
);
    localparam int NW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] tx_q;
    logic [NW-1:0]     nfall_q;

    assign mosi      = run ? tx_q[BYTE_W-1] : 1'b0;
    assign last_fall = run && tick && sclk && (nfall_q == NW'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_byte <= '0;
            sclk    <= 1'b0;
            nfall_q <= '0;
        end else if (load) begin
            tx_q    <= din;
            rx_byte <= '0;
            sclk    <= 1'b0;
            nfall_q <= '0;
        end else if (run && tick) begin
            if (!sclk) begin
                sclk    <= 1'b1;
                rx_byte <= {rx_byte[BYTE_W-2:0], miso};
            end else begin
                sclk    <= 1'b0;
                tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                nfall_q <= nfall_q + 1'b1;
            end
        end
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4
    nfall_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nfall_q <= NW'(BYTE_W));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_shift_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int BYTE_W   = 8,
    parameter int REG_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [1:0]       cs_n
);
    logic [REG_W-1:0]  data_q;
    logic [1:0]        sel_q;
    logic              dir_q;
    logic              stb_q;
    logic              load, run, loaded, done, tick, last_fall;
    logic [BYTE_W-1:0] rx_byte;
    logic [REG_W-1:0]  ctrl_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            dir_q <= 1'b0;
            stb_q <= 1'b0;
        end else if (reg_wr && reg_addr) begin
            sel_q <= {reg_wdata[CB_SEL1], reg_wdata[CB_SEL0]};
            dir_q <= reg_wdata[CB_DIR];
            stb_q <= reg_wdata[CB_STROBE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (last_fall && dir_q)
            data_q <= REG_W'(rx_byte);
        else if (reg_wr && !reg_addr)
            data_q <= reg_wdata;
    end

    always_comb begin
        ctrl_view            = '0;
        ctrl_view[CB_SEL0]   = sel_q[0];
        ctrl_view[CB_SEL1]   = sel_q[1];
        ctrl_view[CB_DIR]    = dir_q;
        ctrl_view[CB_DONE]   = done;
        ctrl_view[CB_STROBE] = stb_q;
        ctrl_view[CB_LOADED] = loaded;
    end

    assign reg_rdata = reg_addr ? ctrl_view : data_q;
    assign cs_n      = ~sel_q;

    spi_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_byte_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (stb_q),
        .last_fall (last_fall),
        .load      (load),
        .run       (run),
        .loaded    (loaded),
        .done      (done)
    );

    spi_byte_shreg #(.BYTE_W(BYTE_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .din       (data_q[BYTE_W-1:0]),
        .run       (run),
        .tick      (tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .last_fall (last_fall)
    );

    // R3
    no_clk_while_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |-> !sclk);

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sclk);

    // R5
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_fall && dir_q) |=> (data_q[REG_W-1:BYTE_W] == '0));
endmodule

// File: tb/spi_byte_shifter_bench.sv
module spi_byte_shifter_bench;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [1:0]  cs_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    int fall_count = 0;
    int base = 0;
    logic [7:0] slave_byte = 8'h00;

    always #4 clk = ~clk;

    assign miso = ((fall_count - base) < 8) ? slave_byte[3'(7 - (fall_count - base))] : 1'b0;

    spi_byte_shifter #(.DIV_HALF(HALF)) u_spi_byte_shifter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: MOSI bytes and SCLK high time
    initial begin
        logic [7:0] cap;
        int bitn;
        int hi;
        logic [7:0] e;
        cap = '0;
        bitn = 0;
        forever begin
            @(posedge sclk);
            cap = {cap[6:0], mosi};
            bitn++;
            hi = 0;
            @(negedge clk);
            while (sclk === 1'b1) begin
                hi++;
                @(negedge clk);
            end
            fall_count++;
            chk(hi == HALF, "R7 sclk high phase", hi, HALF);
            if (bitn == 8) begin
                bitn = 0;
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", cap, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(cap == e, "R4 mosi byte", cap, e);
                end
            end
        end
    end

    task automatic write_reg(input logic a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic xfer(input logic [1:0] sel, input logic rd, input logic [7:0] txb,
                        input logic [7:0] sb, output logic [7:0] got);
        logic [15:0] v;
        int n;
        write_reg(1'b0, {8'h00, txb});
        base = fall_count;
        slave_byte = sb;
        exp_q.push_back(txb);
        write_reg(1'b1, {11'b0, 1'b1, 1'b0, rd, sel});
        read_reg(1'b1, v);
        chk(v[5] == 1'b0, "R2 loaded before accept", v, 0);
        @(negedge clk);
        read_reg(1'b1, v);
        chk(v[5] == 1'b1 && v[3] == 1'b0, "R2 loaded set, done cleared", v, 32'h20);
        repeat (4) @(negedge clk);
        read_reg(1'b1, v);
        chk(v[5] == 1'b1 && sclk == 1'b0, "R3 held while strobe high", {v[5], sclk}, 2'b10);
        chk(cs_n == ~sel, "R8 select during transfer", cs_n, ~sel);
        write_reg(1'b1, {13'b0, rd, sel});
        n = 0;
        do begin
            @(negedge clk);
            read_reg(1'b1, v);
            n++;
        end while (!v[3] && n < 2000);
        chk(v[3] == 1'b1 && v[5] == 1'b0, "R6 done after byte", v, 32'h8);
        read_reg(1'b0, v);
        got = v[7:0];
        if (rd) chk(v == {8'h00, sb}, "R5 read byte", v, {8'h00, sb});
        else    chk(v == {8'h00, txb}, "R5 data kept on write", v, {8'h00, txb});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  g1, g2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        read_reg(1'b1, v);
        chk(v == 16'h0000, "R1 control after reset", v, 0);
        read_reg(1'b0, v);
        chk(v == 16'h0000, "R1 data after reset", v, 0);
        chk(cs_n == 2'b11 && sclk == 1'b0 && mosi == 1'b0, "R8 idle pins", {cs_n, sclk, mosi}, 4'b1100);

        // R10: read-only positions written high
        write_reg(1'b1, 16'h002A);
        read_reg(1'b1, v);
        chk(v == 16'h0002, "R10 read-only bits ignored", v, 16'h0002);
        chk(cs_n == 2'b01, "R8 select 1 follows bit 1", cs_n, 2'b01);

        // touch: 8-bit write, then read
        xfer(2'b10, 1'b0, 8'hA5, 8'h3C, g1);
        xfer(2'b10, 1'b1, 8'h00, 8'h96, g1);

        // codec: 16-bit write, MSB byte first
        xfer(2'b01, 1'b0, 8'hC3, 8'h00, g1);
        chk(cs_n[0] == 1'b0, "R9 select held between bytes", cs_n, 2'b10);
        xfer(2'b01, 1'b0, 8'h5A, 8'h00, g1);
        chk(cs_n[0] == 1'b0, "R9 select held after word", cs_n, 2'b10);

        // codec: 16-bit read assembled
        xfer(2'b01, 1'b1, 8'h00, 8'h81, g1);
        chk(cs_n[0] == 1'b0, "R9 select held between read bytes", cs_n, 2'b10);
        xfer(2'b01, 1'b1, 8'h00, 8'h7E, g2);
        chk({g1, g2} == 16'h817E, "R9 assembled word", {g1, g2}, 16'h817E);

        // R6: done persists, R1 layout with done
        repeat (10) @(negedge clk);
        read_reg(1'b1, v);
        chk(v == 16'h000D, "R6 R1 done persists", v, 16'h000D);

        // R8: deselect
        write_reg(1'b1, 16'h0000);
        chk(cs_n == 2'b11, "R8 deselect both", cs_n, 2'b11);
        read_reg(1'b1, v);
        chk(v == 16'h0008, "R1 control after deselect", v, 16'h0008);

        chk(exp_q.size() == 0, "R4 all bytes observed", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule